// File: doc/BRIEF.md
# Word-Parallel Gold Sequence Generator

This block generates the length-31 Gold pseudo-random bit sequence that scrambling and reference-signal logic consume. Two 31-bit linear feedback shift registers run side by side. The output sequence is the bitwise XOR of the two. The block delivers 32 consecutive sequence bits per clock whenever the consumer accepts them.

A start strobe captures a 31-bit seed and a skip count. The first register is loaded with a fixed seed and the second with the captured seed. Both registers are then moved forward past a fixed discard prefix plus the requested skip. This move uses precomputed state-jump matrices: each matrix advances a register by a power of two of steps. The block applies one matrix per bit of the combined offset, so the jump takes a fixed number of cycles that does not depend on the offset. After the jump, words stream out under a valid/ready handshake. A new start strobe at any time abandons the current sequence and reseeds.

Top module: `gold_seq_gen`

## Requirements
- R1: While reset is held and after it is released, before any start, valid_o is low and word_o is zero.
- R2: Sequence bit c(n) = x1(n) XOR x2(n). x1 starts with x1(0)=1 and x1(1..30)=0, and follows x1(n+31) = x1(n+3) XOR x1(n).
- R3: x2(i) = cinit_i[i] for i = 0..30, captured when start_i is sampled high. x2 follows x2(n+31) = x2(n+3) XOR x2(n+2) XOR x2(n+1) XOR x2(n).
- R4: The first word after a start holds sequence indices DISCARD+skip_i through DISCARD+skip_i+31, with DISCARD = 1600 by default.
- R5: Within word_o, bit i holds sequence index n+i, so bit 0 is the earliest index.
- R6: Each edge with valid_o and ready_i both high (and start_i low) advances the stream by exactly 32 indices, so accepted words are contiguous.
- R7: Once valid_o is high it stays high until the next start. While ready_i is low, word_o holds its value.
- R8: valid_o rises exactly ADV_W clock edges after the edge that sampled start_i, whatever the skip value. ADV_W = 17 with the default parameters.
- R9: start_i sampled high at any time, during the jump or during output, drops valid_o on the next cycle and restarts from the new seed and skip.
- R10: word_o is zero whenever valid_o is low.
- R11: Every skip_i value from 0 to 2^SKIP_W-1 is honoured, including the largest one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Seed strobe; restarts the sequence |
| cinit_i | input | 31 | Seed for the second register, bit i = x2(i) |
| skip_i | input | SKIP_W | Extra offset beyond the discard prefix |
| ready_i | input | 1 | Consumer accepts word_o this cycle |
| word_o | output | 32 | 32 sequence bits, LSB earliest |
| valid_o | output | 1 | word_o holds sequence bits |

## Verification
The assertions check the handshake behaviour on every cycle. Idle output is zero, and a stalled word holds. valid_o persists until a restart and drops right after any start strobe. The rise of valid_o is counted against the fixed jump latency. Sequence content cannot be checked by these assertions: the polynomials, the seed placement, the discard-plus-skip offset, bit order and the contiguity of accepted words. Only the bench shows those, by comparing every cycle against a bit-serial model. The model is exercised across several seeds, skip values up to the largest, random stalls, and restarts both during the jump and mid-stream.

// File: rtl/gold_seq_pkg.sv
package gold_seq_pkg;
  localparam int unsigned RegLen = 31;
  localparam int unsigned WordW  = 32;
  // feedback taps: x(n+31) = XOR of x(n+t) for each set bit t
  localparam logic [RegLen-1:0] X1_TAPS = 31'h0000_0009;
  localparam logic [RegLen-1:0] X2_TAPS = 31'h0000_000F;
  localparam logic [RegLen-1:0] X1_SEED = 31'h0000_0001;

  typedef logic [RegLen-1:0] lfsr_t;
  typedef lfsr_t [RegLen-1:0] jmat_t; // row r: mask of old bits feeding new bit r

  typedef enum logic [1:0] {ST_IDLE, ST_JUMP, ST_RUN} gen_st_e;

  function automatic jmat_t step_mat(lfsr_t taps);
    jmat_t m;
    for (int r = 0; r < RegLen; r++) begin
      m[r] = '0;
      if (r < RegLen - 1) m[r][r+1] = 1'b1;
      else                m[r]      = taps;
    end
    return m;
  endfunction

  // product a*b: apply b first, then a
  function automatic jmat_t mat_mul(jmat_t a, jmat_t b);
    jmat_t p;
    for (int r = 0; r < RegLen; r++) begin
      lfsr_t acc;
      acc = '0;
      for (int c = 0; c < RegLen; c++)
        if (a[r][c]) acc = acc ^ b[c];
      p[r] = acc;
    end
    return p;
  endfunction

  function automatic jmat_t pow2_mat(lfsr_t taps, int unsigned k);
    jmat_t m;
    m = step_mat(taps);
    for (int unsigned i = 0; i < k; i++) m = mat_mul(m, m);
    return m;
  endfunction

  function automatic lfsr_t mat_vec(jmat_t m, lfsr_t s);
    lfsr_t v;
    for (int r = 0; r < RegLen; r++) v[r] = ^(m[r] & s);
    return v;
  endfunction
endpackage

// File: rtl/gold_lfsr_word.sv
module gold_lfsr_word
  import gold_seq_pkg::*;
#(
  parameter lfsr_t TAPS = X1_TAPS
) (
  input  lfsr_t             state_i,
  output logic [WordW-1:0]  bits_o,
  output lfsr_t             next_o
);
  // window of 31 consecutive bits, bit 0 = current index
  always_comb begin
    lfsr_t w;
    w = state_i;
    for (int j = 0; j < WordW; j++) begin
      bits_o[j] = w[0];
      w = {^(w & TAPS), w[RegLen-1:1]};
    end
    next_o = w;
  end
endmodule

// File: rtl/gold_jump.sv
module gold_jump
  import gold_seq_pkg::*;
#(
  parameter lfsr_t       TAPS = X1_TAPS,
  parameter int unsigned NJ   = 17,
  parameter int unsigned KW   = 5
) (
  input  lfsr_t          state_i,
  input  logic           en_i,
  input  logic [KW-1:0]  sel_i,
  output lfsr_t          state_o
);
  lfsr_t cand [NJ];

  for (genvar k = 0; k < NJ; k++) begin : g_pow
    localparam jmat_t JM = pow2_mat(TAPS, k);
    assign cand[k] = mat_vec(JM, state_i);
  end

  assign state_o = en_i ? cand[sel_i] : state_i;
endmodule

// File: rtl/gold_seq_ctrl.sv
module gold_seq_ctrl
  import gold_seq_pkg::*;
#(
  parameter int unsigned ADV_W = 17,
  parameter int unsigned KW    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ready_i,
  input  logic [ADV_W-1:0]  adv_i,
  output logic              load_o,
  output logic              jump_en_o,
  output logic [KW-1:0]     jump_sel_o,
  output logic              step_o,
  output logic              valid_o
);
  localparam logic [KW-1:0] KLast = KW'(ADV_W - 1);

  gen_st_e          st_q;
  logic [KW-1:0]    k_q;
  logic [ADV_W-1:0] adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      k_q   <= '0;
      adv_q <= '0;
    end else if (start_i) begin
      st_q  <= ST_JUMP;
      k_q   <= '0;
      adv_q <= adv_i;
    end else if (st_q == ST_JUMP) begin
      k_q <= k_q + 1'b1;
      if (k_q == KLast) st_q <= ST_RUN;
    end
  end

  assign load_o     = start_i;
  assign jump_en_o  = (st_q == ST_JUMP) && adv_q[k_q] && !start_i;
  assign jump_sel_o = k_q;
  assign valid_o    = (st_q == ST_RUN);
  assign step_o     = (st_q == ST_RUN) && ready_i && !start_i;
endmodule

// File: rtl/gold_seq_gen.sv
module gold_seq_gen
  import gold_seq_pkg::*;
#(
  parameter int unsigned SKIP_W  = 16,
  parameter int unsigned DISCARD = 1600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [30:0]       cinit_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic              ready_i,
  output logic [31:0]       word_o,
  output logic              valid_o
);
  localparam int unsigned ADV_W = $clog2(DISCARD + (2 ** SKIP_W));
  localparam int unsigned KW    = (ADV_W > 1) ? $clog2(ADV_W) : 1;

  logic [ADV_W-1:0] adv_d;
  logic             load, jump_en, step, run;
  logic [KW-1:0]    jump_sel;
  lfsr_t            x1_q, x2_q, x1_jmp, x2_jmp, x1_nxt, x2_nxt;
  logic [WordW-1:0] w1, w2;

  assign adv_d = ADV_W'(DISCARD) + ADV_W'(skip_i);

  gold_seq_ctrl #(.ADV_W(ADV_W), .KW(KW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_i(ready_i),
    .adv_i(adv_d), .load_o(load), .jump_en_o(jump_en), .jump_sel_o(jump_sel),
    .step_o(step), .valid_o(run)
  );

  gold_jump #(.TAPS(X1_TAPS), .NJ(ADV_W), .KW(KW)) u_jump_x1 (
    .state_i(x1_q), .en_i(jump_en), .sel_i(jump_sel), .state_o(x1_jmp)
  );
  gold_jump #(.TAPS(X2_TAPS), .NJ(ADV_W), .KW(KW)) u_jump_x2 (
    .state_i(x2_q), .en_i(jump_en), .sel_i(jump_sel), .state_o(x2_jmp)
  );

  gold_lfsr_word #(.TAPS(X1_TAPS)) u_word_x1 (.state_i(x1_q), .bits_o(w1), .next_o(x1_nxt));
  gold_lfsr_word #(.TAPS(X2_TAPS)) u_word_x2 (.state_i(x2_q), .bits_o(w2), .next_o(x2_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      x2_q <= '0;
    end else if (load) begin
      x1_q <= X1_SEED;
      x2_q <= cinit_i;
    end else if (jump_en) begin
      x1_q <= x1_jmp;
      x2_q <= x2_jmp;
    end else if (step) begin
      x1_q <= x1_nxt;
      x2_q <= x2_nxt;
    end
  end

  assign valid_o = run;
  assign word_o  = run ? (w1 ^ w2) : '0;
endmodule

// File: rtl/gold_seq_chk.sv
module gold_seq_chk #(
  parameter int unsigned LAT = 17
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        ready_i,
  input logic [31:0] word_o,
  input logic        valid_o
);
  localparam int unsigned CW = $clog2(LAT + 2) + 1;
  localparam logic [CW-1:0] CMax = '1;

  logic [CW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_q <= CMax;
    else if (start_i)           since_q <= '0;
    else if (since_q != CMax)   since_q <= since_q + 1'b1;
  end

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> word_o == 32'h0);

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !start_i |=> valid_o && $stable(word_o));

  p_stay_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !start_i |=> valid_o);

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> since_q == CW'(LAT));
endmodule

bind gold_seq_gen gold_seq_chk #(.LAT(ADV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_i(ready_i),
  .word_o(word_o), .valid_o(valid_o)
);

// File: tb/gold_seq_gen_bench.sv
module gold_seq_gen_bench;
  localparam int SKIP_W  = 16;
  localparam int DISCARD = 1600;
  localparam int LAT     = 17;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [30:0]       cinit_i = '0;
  logic [SKIP_W-1:0] skip_i = '0;
  logic              ready_i = 1'b0;
  logic [31:0]       word_o;
  logic              valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  bit [30:0] m1, m2;
  int        lat;
  bit        started = 1'b0;

  always #5 clk = ~clk;

  gold_seq_gen #(.SKIP_W(SKIP_W), .DISCARD(DISCARD)) u_gold_seq_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cinit_i(cinit_i),
    .skip_i(skip_i), .ready_i(ready_i), .word_o(word_o), .valid_o(valid_o)
  );

  task automatic model_step();
    m1 = {m1[0] ^ m1[3], m1[30:1]};
    m2 = {m2[0] ^ m2[1] ^ m2[2] ^ m2[3], m2[30:1]};
  endtask

  function automatic logic [31:0] model_word();
    bit [30:0] a, b;
    logic [31:0] w;
    a = m1; b = m2;
    for (int i = 0; i < 32; i++) begin
      w[i] = a[0] ^ b[0];
      a = {a[0] ^ a[3], a[30:1]};
      b = {b[0] ^ b[1] ^ b[2] ^ b[3], b[30:1]};
    end
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic start_seq(logic [30:0] ci, logic [SKIP_W-1:0] sk);
    start_i = 1'b1; cinit_i = ci; skip_i = sk; ready_i = 1'b0;
    m1 = 31'h1; m2 = ci;
    repeat (DISCARD + int'(sk)) model_step();
    lat = 0; started = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // mode 0: always ready, 1: random, 2: mostly stalled
  task automatic run_seq(int cycles, int mode, string tag);
    for (int c = 0; c < cycles; c++) begin
      bit exp_v;
      bit rdy;
      exp_v = started && (lat >= LAT);
      check("R8 valid", {31'h0, valid_o}, {31'h0, exp_v});
      if (exp_v) check(tag, word_o, model_word());
      else       check("R10 idle word", word_o, 32'h0);
      case (mode)
        0:       rdy = 1'b1;
        1:       rdy = $urandom_range(0, 1) == 1;
        default: rdy = $urandom_range(0, 3) == 0;
      endcase
      ready_i = rdy;
      if (exp_v && rdy) repeat (32) model_step();
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'h0, valid_o}, 32'h0);
    check("R1 reset word", word_o, 32'h0);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1 idle valid", {31'h0, valid_o}, 32'h0);
      check("R1 idle word", word_o, 32'h0);
    end

    start_seq(31'h0, 16'd0);           run_seq(40, 0, "R2 x1-only");
    start_seq(31'h1234567, 16'd0);     run_seq(40, 0, "R3/R5 seeded");
    start_seq(31'h7fffffff, 16'd37);   run_seq(40, 0, "R4 odd skip");
    start_seq(31'h2b5e1c93, 16'd1000); run_seq(80, 1, "R6/R7 random stall");
    start_seq(31'h0a5a5a5a, 16'd64);   run_seq(60, 2, "R7 heavy stall");
    start_seq(31'h15d2a0f1, 16'hffff); run_seq(40, 0, "R11 max skip");
    start_seq(31'h00000abc, 16'd5);    run_seq(30, 0, "R9 before restart");
    start_seq(31'h3c3c3c3c, 16'd9);    run_seq(30, 1, "R9 restart mid-run");
    start_seq(31'h4444_4444, 16'd3);   run_seq(6, 0, "R9 jump phase");
    start_seq(31'h1111_2222, 16'd777); run_seq(40, 1, "R9 restart in jump");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule